// File: doc/BRIEF.md
# Motor PWM Drive with Speed Ramp

This block turns a commanded speed into a pulse-width-modulated motor drive and a pair of direction pins. The commanded speed is an 8-bit word: the top bit selects forward (1) or reverse (0), and the low seven bits give a step from 0 to 127. The block keeps its own current speed and moves it toward the command one step at a time. Separate acceleration and deceleration rates set how fast it rises and falls. A rate of zero makes the speed jump straight to the command.

The PWM period is set by a 4-bit value P. The on-time inside that period is proportional to P times the current speed, so the duty cycle is speed/128 whatever P is. The ramp is evaluated once per PWM period, at the period boundary. An accumulator gains P at each boundary and pays out one speed step each time it reaches the active rate. As a result, a longer period gives a faster ramp per boundary.

A reversal request first ramps the speed down to zero, and only then flips the direction. An emergency-stop strobe zeroes the current speed on the next clock edge. A normal stop is simply a command of zero speed, which then follows the deceleration ramp.

Top module: `mpwm_motor_drive`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears the current speed to 0, the direction to reverse (dir_fwd=0, dir_rev=1) and the accumulator, and restarts the period counter. pwm_out is 0 in this state.
- R2: The period value P is the 4-bit period_set. A value of 0 is replaced by 8. The PWM period is (P << STEP_SHIFT) × 128 clocks, and pwm_out is high for the first (P × speed) << STEP_SHIFT clocks of it.
- R3: pwm_out stays low for the whole period whenever the current speed magnitude is 0.
- R4: The speed magnitude changes only at a period boundary or on an emergency stop. At a boundary it moves by at most one step when the active rate is nonzero. The active rate is accel_rate when the effective target is above the current speed, and decel_rate when it is below.
- R5: At each boundary where the target differs from the current speed, the accumulator gains P. When the sum reaches the active rate, the rate is subtracted and the speed takes one step.
- R6: If the active rate is 0, the speed takes the value of the effective target at the next boundary.
- R7: The current direction changes only at a boundary where the current speed is 0 and equal to the effective target. At such a boundary the accumulator is also cleared.
- R8: When the commanded direction (desired_speed bit 7) differs from the current direction, the effective target is 0. The speed therefore ramps down at the decel rate before the direction flips.
- R9: A one-cycle emergency stop forces the speed magnitude to 0 on the next clock edge and leaves the direction unchanged. A command of zero speed instead decelerates through the ramp.
- R10: The direction pins are complementary: dir_fwd=1 and dir_rev=0 for forward, and the reverse for backward. cur_speed reports {direction, magnitude} in the same format as desired_speed.
- R11: period_set, and with it the period length and on-time scale, is sampled only at a period boundary. A change made mid-period takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| desired_speed | input | 8 | Commanded speed: bit 7 forward, bits 6:0 step |
| period_set | input | 4 | PWM period value P, 0 means 8 |
| accel_rate | input | 8 | Accumulator threshold per step when rising, 0 = jump |
| decel_rate | input | 8 | Accumulator threshold per step when falling, 0 = jump |
| estop | input | 1 | Emergency stop strobe |
| pwm_out | output | 1 | Motor PWM drive |
| dir_fwd | output | 1 | Direction pin, high for forward |
| dir_rev | output | 1 | Direction pin, high for reverse |
| cur_speed | output | 8 | Current speed: bit 7 direction, bits 6:0 step |

## Verification
The hardest situation to reach is a direction reversal that is still in progress while the accumulator is carrying a remainder. In that state the speed must fall step by step while the direction pins keep their old value, and the pins may flip only at the boundary after zero is reached. The bench gets there by running a fixed sequence without resetting between steps. It first ramps up with P=2 and an acceleration rate that is not a multiple of P, then decelerates and jumps with a zero rate. Only then does it command the opposite direction with a deceleration rate smaller than P. Each stage is checked at exact period boundaries. An emergency stop and then a normal stop are applied on top of the resulting state, so that the leftover accumulator value decides the expected step.

// File: rtl/mpwm_pkg.sv
// Shared constants and helpers for the motor PWM drive.
// Assumes the period value is a 4-bit field and the speed magnitude is 7 bits.
package mpwm_pkg;
    localparam int unsigned PER_W       = 4;
    localparam int unsigned SPD_W       = 7;
    localparam int unsigned RATE_W      = 8;
    localparam int unsigned DEFAULT_PER = 8;

    // Replace an all-zero period value with the default.
    function automatic logic [PER_W-1:0] norm_period(input logic [PER_W-1:0] raw);
        return (raw == '0) ? PER_W'(DEFAULT_PER) : raw;
    endfunction
endpackage

// File: rtl/mpwm_period_gen.sv
// Period generator: latches the period value at each boundary and counts
// clocks through one PWM period of (P << STEP_SHIFT) * 2^SPD_W ticks.
// Assumes the latched P is never zero (norm_period guarantees it).
module mpwm_period_gen #(
    parameter int unsigned PER_W      = mpwm_pkg::PER_W,
    parameter int unsigned SPD_W      = mpwm_pkg::SPD_W,
    parameter int unsigned STEP_SHIFT = 3,
    localparam int unsigned CNT_W     = PER_W + STEP_SHIFT + SPD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period_set,
    output logic [PER_W-1:0] per_q,
    output logic [CNT_W-1:0] tick,
    output logic             per_end
);
    logic [CNT_W-1:0] per_len;
    logic [CNT_W-1:0] last_tick;

    // Period length and last tick index of the running period.
    always_comb begin
        per_len   = CNT_W'(per_q) << (STEP_SHIFT + SPD_W);
        last_tick = per_len - CNT_W'(1);
        per_end   = (tick == last_tick);
    end

    // Tick counter and boundary-time sampling of the period value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick  <= '0;
            per_q <= mpwm_pkg::norm_period(period_set);
        end else if (per_end) begin
            tick  <= '0;
            per_q <= mpwm_pkg::norm_period(period_set);
        end else begin
            tick  <= tick + CNT_W'(1);
        end
    end

    // R11: the period value moves only at a boundary.
    assert_period_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !per_end |=> $stable(per_q));
endmodule

// File: rtl/mpwm_ramp.sv
// Speed ramp: once per PWM period it moves the current speed toward the
// effective target through a P-weighted accumulator. The direction flips
// only at zero speed. An emergency stop zeroes the speed at once.
// Assumes per_end is a one-cycle strobe at the last tick of each period.
module mpwm_ramp #(
    parameter int unsigned PER_W  = mpwm_pkg::PER_W,
    parameter int unsigned SPD_W  = mpwm_pkg::SPD_W,
    parameter int unsigned RATE_W = mpwm_pkg::RATE_W,
    localparam int unsigned ACC_W = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_end,
    input  logic [PER_W-1:0]  per_q,
    input  logic [SPD_W:0]    desired,
    input  logic [RATE_W-1:0] accel,
    input  logic [RATE_W-1:0] decel,
    input  logic              estop,
    output logic [SPD_W-1:0]  spd_q,
    output logic              dir_q
);
    logic [ACC_W-1:0]  acc_q, acc_n, acc_sum;
    logic [ACC_W:0]    sum_w;
    logic [SPD_W-1:0]  spd_n, tgt;
    logic              dir_n, rising;
    logic [RATE_W-1:0] rate;

    // Effective target, active rate and saturating accumulator sum.
    always_comb begin
        tgt     = (desired[SPD_W] != dir_q) ? '0 : desired[SPD_W-1:0];
        rising  = (tgt > spd_q);
        rate    = rising ? accel : decel;
        sum_w   = {1'b0, acc_q} + (ACC_W+1)'(per_q);
        acc_sum = sum_w[ACC_W] ? '1 : sum_w[ACC_W-1:0];
    end

    // Next-state decision for speed, direction and accumulator.
    always_comb begin
        spd_n = spd_q;
        dir_n = dir_q;
        acc_n = acc_q;
        if (per_end) begin
            if (tgt == spd_q) begin
                acc_n = '0;
                dir_n = desired[SPD_W];
            end else begin
                acc_n = acc_sum;
                if (rate == '0) begin
                    spd_n = tgt;
                end else if (acc_sum >= ACC_W'(rate)) begin
                    acc_n = acc_sum - ACC_W'(rate);
                    spd_n = rising ? spd_q + SPD_W'(1) : spd_q - SPD_W'(1);
                end
            end
        end
        if (estop) spd_n = '0;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q <= '0;
            dir_q <= 1'b0;
            acc_q <= '0;
        end else begin
            spd_q <= spd_n;
            dir_q <= dir_n;
            acc_q <= acc_n;
        end
    end

    // R4: the speed is frozen between boundaries unless an emergency stop occurs.
    assert_speed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!per_end && !estop) |=> $stable(spd_q));
    // R4: with a nonzero rate a boundary moves the speed by at most one step.
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end && !estop && rate != '0) |=>
            (spd_q == $past(spd_q)) || (spd_q == $past(spd_q) + SPD_W'(1))
            || (spd_q == $past(spd_q) - SPD_W'(1)));
    // R7: the direction changes only when the speed was zero.
    assert_dir_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_q) |-> ($past(spd_q) == '0));
    // R9: an emergency stop leaves zero speed on the next edge.
    assert_estop_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        estop |=> (spd_q == '0));
endmodule

// File: rtl/mpwm_pwm_out.sv
// PWM comparator: the output is high while the tick count is below
// (P * speed) << STEP_SHIFT, which gives a duty cycle of speed / 2^SPD_W.
// Assumes tick restarts at 0 on each period boundary.
module mpwm_pwm_out #(
    parameter int unsigned PER_W      = mpwm_pkg::PER_W,
    parameter int unsigned SPD_W      = mpwm_pkg::SPD_W,
    parameter int unsigned STEP_SHIFT = 3,
    localparam int unsigned CNT_W     = PER_W + STEP_SHIFT + SPD_W
) (
    input  logic [CNT_W-1:0] tick,
    input  logic [PER_W-1:0] per_q,
    input  logic [SPD_W-1:0] spd,
    output logic             pwm
);
    logic [CNT_W-1:0] on_ticks;

    // On-time from the latched period value and the current speed.
    always_comb begin
        on_ticks = CNT_W'(CNT_W'(per_q) * CNT_W'(spd)) << STEP_SHIFT;
        pwm      = (spd != '0) && (tick < on_ticks);
    end
endmodule

// File: rtl/mpwm_motor_drive.sv
// Top level of the motor PWM drive: period generator, speed ramp and PWM
// comparator. Direction pins are driven complementary from the ramp's direction.
// Assumes estop is synchronous to clk.
module mpwm_motor_drive #(
    parameter int unsigned PER_W      = mpwm_pkg::PER_W,
    parameter int unsigned SPD_W      = mpwm_pkg::SPD_W,
    parameter int unsigned RATE_W     = mpwm_pkg::RATE_W,
    parameter int unsigned STEP_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPD_W:0]    desired_speed,
    input  logic [PER_W-1:0]  period_set,
    input  logic [RATE_W-1:0] accel_rate,
    input  logic [RATE_W-1:0] decel_rate,
    input  logic              estop,
    output logic              pwm_out,
    output logic              dir_fwd,
    output logic              dir_rev,
    output logic [SPD_W:0]    cur_speed
);
    localparam int unsigned CNT_W = PER_W + STEP_SHIFT + SPD_W;

    logic [PER_W-1:0] per_q;
    logic [CNT_W-1:0] tick;
    logic             per_end;
    logic [SPD_W-1:0] spd_q;
    logic             dir_q;

    mpwm_period_gen #(.PER_W(PER_W), .SPD_W(SPD_W), .STEP_SHIFT(STEP_SHIFT)) u_period (
        .clk(clk), .rst_n(rst_n), .period_set(period_set),
        .per_q(per_q), .tick(tick), .per_end(per_end));

    mpwm_ramp #(.PER_W(PER_W), .SPD_W(SPD_W), .RATE_W(RATE_W)) u_ramp (
        .clk(clk), .rst_n(rst_n), .per_end(per_end), .per_q(per_q),
        .desired(desired_speed), .accel(accel_rate), .decel(decel_rate),
        .estop(estop), .spd_q(spd_q), .dir_q(dir_q));

    mpwm_pwm_out #(.PER_W(PER_W), .SPD_W(SPD_W), .STEP_SHIFT(STEP_SHIFT)) u_pwm (
        .tick(tick), .per_q(per_q), .spd(spd_q), .pwm(pwm_out));

    // Port mapping of direction and reported speed.
    always_comb begin
        dir_fwd   = dir_q;
        dir_rev   = ~dir_q;
        cur_speed = {dir_q, spd_q};
    end

    // R3: no drive pulse while the reported speed is zero.
    assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_speed[SPD_W-1:0] == '0) |-> !pwm_out);
endmodule

// File: tb/mpwm_motor_drive_tb.sv
`timescale 1ns/1ps
module mpwm_motor_drive_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] desired_speed = 8'h00;
    logic [3:0] period_set = 4'd1;
    logic [7:0] accel_rate = 8'd0;
    logic [7:0] decel_rate = 8'd0;
    logic       estop = 1'b0;
    logic       pwm_out, dir_fwd, dir_rev;
    logic [7:0] cur_speed;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // STEP_SHIFT = 0: period is P * 128 clocks, on-time is P * speed clocks.
    mpwm_motor_drive #(.STEP_SHIFT(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .desired_speed(desired_speed),
        .period_set(period_set), .accel_rate(accel_rate), .decel_rate(decel_rate),
        .estop(estop), .pwm_out(pwm_out), .dir_fwd(dir_fwd), .dir_rev(dir_rev),
        .cur_speed(cur_speed));

    // Vector: {period_set, desired_speed, expected high clocks per period}
    localparam int NVEC = 7;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd1,  8'h80, 16'd0},
        {4'd1,  8'hC0, 16'd64},
        {4'd3,  8'hE4, 16'd300},
        {4'd0,  8'h85, 16'd40},
        {4'd15, 8'hFF, 16'd1905},
        {4'd2,  8'h01, 16'd2},
        {4'd4,  8'h00, 16'd0}
    };

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int plen(input logic [3:0] p);
        return ((p == 4'd0) ? 8 : int'(p)) * 128;
    endfunction

    task automatic do_reset(input logic [3:0] p, input logic [7:0] des,
                            input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        rst_n = 1'b0; period_set = p; desired_speed = des;
        accel_rate = a; decel_rate = d; estop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_periods(input int k, input int len);
        repeat (k * len) @(negedge clk);
    endtask

    task automatic count_high(input int len, output int n);
        n = 0;
        repeat (len) begin
            n += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    initial begin
        int hi;
        int len;
        // Reset state straight after power-up (R1)
        do_reset(4'd1, 8'h00, 8'd0, 8'd0);
        check_eq("R1 speed after reset", cur_speed, 0);
        check_eq("R1 dir_rev after reset", dir_rev, 1);
        check_eq("R1 pwm after reset", pwm_out, 0);

        // Table walk: duty and period (R2, R3, R6, R10)
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0]  vp;
            logic [7:0]  vd;
            logic [15:0] vh;
            {vp, vd, vh} = VEC[i];
            do_reset(vp, vd, 8'd0, 8'd0);
            len = plen(vp);
            run_periods(2, len);
            check_eq("R6 speed jumped to target", cur_speed, vd);
            count_high(len, hi);
            check_eq("R2 R3 high clocks per period", hi, vh);
            check_eq("R10 dir_fwd", dir_fwd, vd[7]);
            check_eq("R10 dir_rev", dir_rev, !vd[7]);
        end

        // Reset while running (R1)
        do_reset(4'd1, 8'hC0, 8'd0, 8'd0);
        run_periods(2, 128);
        do_reset(4'd1, 8'hC0, 8'd0, 8'd0);
        check_eq("R1 speed cleared by reset", cur_speed, 0);
        check_eq("R1 dir_fwd cleared by reset", dir_fwd, 0);

        // Period sampled at a boundary (R11)
        run_periods(2, 128);
        period_set = 4'd2;
        count_high(128, hi);
        check_eq("R11 old period kept", hi, 64);
        count_high(256, hi);
        check_eq("R11 new period applied", hi, 128);

        // Weighted ramp up then down: P=2, accel 5, decel 2 (R4, R5)
        do_reset(4'd2, 8'h8A, 8'd5, 8'd2);
        len = 256;
        run_periods(3, len);
        check_eq("R5 no step before threshold", cur_speed, 8'h80);
        run_periods(1, len);
        check_eq("R5 first step", cur_speed, 8'h81);
        run_periods(1, len);
        check_eq("R5 remainder carried", cur_speed, 8'h81);
        run_periods(1, len);
        check_eq("R5 second step", cur_speed, 8'h82);
        desired_speed = 8'h80;
        run_periods(1, len);
        check_eq("R4 decel step", cur_speed, 8'h81);
        run_periods(1, len);
        check_eq("R4 decel to zero", cur_speed, 8'h80);

        // Zero rate jump (R6)
        desired_speed = 8'h83; accel_rate = 8'd0;
        run_periods(1, len);
        check_eq("R6 jump with zero accel", cur_speed, 8'h83);

        // Reversal ramps down first (R7, R8)
        desired_speed = 8'h03; decel_rate = 8'd1;
        run_periods(1, len);
        check_eq("R8 reversal ramps down", cur_speed, 8'h82);
        run_periods(1, len);
        check_eq("R8 reversal second step", cur_speed, 8'h81);
        run_periods(1, len);
        check_eq("R7 direction held at zero", cur_speed, 8'h80);
        check_eq("R7 dir_fwd still set", dir_fwd, 1);
        run_periods(1, len);
        check_eq("R7 direction flipped", cur_speed, 8'h00);
        check_eq("R10 dir_rev after flip", dir_rev, 1);
        run_periods(1, len);
        check_eq("R6 reverse speed", cur_speed, 8'h03);

        // Emergency stop vs normal stop (R9)
        estop = 1'b1;
        @(negedge clk);
        estop = 1'b0;
        check_eq("R9 estop zeroes speed", cur_speed, 8'h00);
        check_eq("R9 pwm off after estop", pwm_out, 0);
        repeat (len - 1) @(negedge clk);
        check_eq("R9 target kept after estop", cur_speed, 8'h03);
        desired_speed = 8'h00; decel_rate = 8'd4;
        @(negedge clk);
        check_eq("R9 normal stop not immediate", cur_speed, 8'h03);
        repeat (len - 1) @(negedge clk);
        check_eq("R9 normal stop ramps", cur_speed, 8'h02);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule